// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Controller

This block sequences 32-bit instructions through three stages: fetch, decode and execute. It drives a word-aligned byte address to an instruction memory and reads the returned word in the same cycle. The fetched word moves into a decode register and then into an execute register. Each stage carries the address its instruction came from. Because the program counter is always the fetch address, an instruction in execute sees a PC two words ahead of its own address.

Each instruction is reduced to a class taken from its top byte: normal, load or branch-with-link.
- A load stays in execute for extra sub-steps (a memory step, then a writeback step). While it does, the younger stages are frozen.
- A branch-with-link in execute writes its return address to a link port and sends fetch to the target. The two younger instructions are discarded.

The block is used as the sequencing skeleton of a small in-order core. Its stage outputs expose exactly which address occupies which stage in every cycle.

Top module: `pipe3_core`

## Requirements
- R1: While reset is high, `imem_addr` is set to 0. In every cycle without a load hold or a redirect, `imem_addr` grows by 4 at the next edge.
- R2: Pipeline fill after reset. In the first cycle after reset, both decode and execute are empty. In the second cycle, decode holds address 0 and execute is still empty. In the third cycle, execute holds address 0.
- R3: Whenever `ex_valid` is high, `imem_addr` equals `ex_addr` + 8.
- R4: Whenever both `dec_valid` and `ex_valid` are high, `dec_addr` equals `ex_addr` + 4.
- R5: A load has top byte 0x40 and `ex_kind` 1.
  - It stays in execute for three cycles, with `ex_phase` 0, then 1, then 2.
  - During the first two of those cycles, `imem_addr`, decode and execute keep their contents.
- R6: A branch-with-link has top byte 0x80 and `ex_kind` 2. For the one cycle it is in execute, `link_we` and `redirect` are high and `link_data` equals its address + 4.
- R7: The branch target is the branch address + 8, plus the low 24 bits of the branch sign-extended and shifted left by 2.
  - The target is fetched in the next cycle, and decode and execute are both empty in that cycle.
  - The target reaches execute two cycles after it is fetched.
- R8: Any other top byte gives `ex_kind` 0. Such an instruction spends one cycle in execute and never raises `link_we` or `redirect`.
- R9: Reset is synchronous and active high. Asserting it in the middle of a run returns the block to the state described in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Fetch byte address (the architectural PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dec_valid | output | 1 | Decode stage holds an instruction |
| dec_addr | output | AW | Address of the instruction in decode |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_addr | output | AW | Address of the instruction in execute |
| ex_kind | output | 2 | Class in execute: 0 normal, 1 load, 2 branch-with-link |
| ex_phase | output | PW | Load sub-step: 0 execute, 1 memory, 2 writeback |
| link_we | output | 1 | Link register write strobe |
| link_data | output | AW | Return address written to the link register |
| redirect | output | 1 | Fetch is being redirected to a branch target |

## Verification
The assertions assume that `imem_rdata` is a pure function of `imem_addr` within the cycle. They also assume that reset is held high for at least one edge before the first checked cycle. The program memory in the bench is a fixed word array indexed by the address, so the first assumption holds by construction. The run starts with reset asserted for several edges. Reset is applied again only on a clock edge.

The stimulus contains the following, chosen so that every class of instruction and both branch directions reach execute:
- a straight-line run that mixes an ordinary opcode byte with an unusual one;
- a load;
- a load in the shadow of a branch, which must be flushed;
- a forward branch;
- a backward branch with a negative offset, which closes a loop through the load again.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;

  localparam logic [7:0] OPC_LOAD   = 8'h40;
  localparam logic [7:0] OPC_BRANCH = 8'h80;

  function automatic kind_e classify(input logic [31:0] word);
    if (word[31:24] == OPC_LOAD)
      return KIND_LOAD;
    else if (word[31:24] == OPC_BRANCH)
      return KIND_BRANCH;
    else
      return KIND_NORMAL;
  endfunction

endpackage

// File: rtl/pipe3_fetch.sv
module pipe3_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP = AW'(4);

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (redirect)
      pc <= target;
    else if (!stall)
      pc <= pc + STEP;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect) |=> (pc == $past(pc) + STEP)); // R1

endmodule

// File: rtl/pipe3_decode.sv
module pipe3_decode
  import pipe3_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          flush,
  input  logic [31:0]   fetch_word,
  input  logic [AW-1:0] fetch_addr,
  output logic          dec_valid,
  output kind_e         dec_kind,
  output logic [23:0]   dec_imm,
  output logic [AW-1:0] dec_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_kind  <= KIND_NORMAL;
      dec_imm   <= '0;
      dec_addr  <= '0;
    end else if (flush) begin
      dec_valid <= 1'b0;
    end else if (!stall) begin
      dec_valid <= 1'b1;
      dec_kind  <= classify(fetch_word);
      dec_imm   <= fetch_word[23:0];
      dec_addr  <= fetch_addr;
    end
  end

  AST_DEC_FLUSH: assert property (@(posedge clk) disable iff (rst)
    flush |=> !dec_valid); // R7

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> $stable(dec_addr) && $stable(dec_valid)); // R5

endmodule

// File: rtl/pipe3_execute.sv
module pipe3_execute
  import pipe3_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LOAD_EXTRA = 2,
  parameter int PW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  kind_e         dec_kind,
  input  logic [23:0]   dec_imm,
  input  logic [AW-1:0] dec_addr,
  input  logic [AW-1:0] pc,
  output logic          ex_valid,
  output kind_e         ex_kind,
  output logic [AW-1:0] ex_addr,
  output logic [PW-1:0] ex_phase,
  output logic          stall,
  output logic          redirect,
  output logic [AW-1:0] target,
  output logic          link_we,
  output logic [AW-1:0] link_data
);
  localparam logic [AW-1:0] LINK_OFS = AW'(4);
  localparam int            SEXT_W   = AW - 26;

  logic [23:0]   ex_imm;
  logic [AW-1:0] offset;

  assign offset    = {{SEXT_W{ex_imm[23]}}, ex_imm, 2'b00};
  assign redirect  = ex_valid && (ex_kind == KIND_BRANCH);
  assign target    = pc + offset;
  assign link_we   = redirect;
  assign link_data = ex_addr + LINK_OFS;

  generate
    if (LOAD_EXTRA == 0) begin : g_no_hold
      assign stall    = 1'b0;
      assign ex_phase = '0;
    end else begin : g_hold
      localparam logic [PW-1:0] LAST = PW'(LOAD_EXTRA);
      logic [PW-1:0] phase_q;
      assign stall    = ex_valid && (ex_kind == KIND_LOAD) && (phase_q != LAST);
      assign ex_phase = phase_q;

      always_ff @(posedge clk) begin
        if (rst || redirect || !stall)
          phase_q <= '0;
        else
          phase_q <= phase_q + PW'(1);
      end

      AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST); // R5

      AST_PHASE_ADV: assert property (@(posedge clk) disable iff (rst)
        stall |=> (phase_q == $past(phase_q) + PW'(1)) && $stable(ex_addr)); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_kind  <= KIND_NORMAL;
      ex_imm   <= '0;
      ex_addr  <= '0;
    end else if (redirect) begin
      ex_valid <= 1'b0;
    end else if (!stall) begin
      ex_valid <= dec_valid;
      ex_kind  <= dec_kind;
      ex_imm   <= dec_imm;
      ex_addr  <= dec_addr;
    end
  end

endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LOAD_EXTRA = 2,
  parameter int PW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic          dec_valid,
  output logic [AW-1:0] dec_addr,
  output logic          ex_valid,
  output logic [AW-1:0] ex_addr,
  output logic [1:0]    ex_kind,
  output logic [PW-1:0] ex_phase,
  output logic          link_we,
  output logic [AW-1:0] link_data,
  output logic          redirect
);
  localparam logic [AW-1:0] AHEAD2 = AW'(8);
  localparam logic [AW-1:0] AHEAD1 = AW'(4);

  logic          stall;
  logic [AW-1:0] target;
  logic [AW-1:0] pc;
  kind_e         dec_kind_w;
  logic [23:0]   dec_imm_w;
  kind_e         ex_kind_w;

  pipe3_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .stall(stall), .redirect(redirect),
    .target(target), .pc(pc)
  );

  pipe3_decode #(.AW(AW)) u_decode (
    .clk(clk), .rst(rst), .stall(stall), .flush(redirect),
    .fetch_word(imem_rdata), .fetch_addr(pc),
    .dec_valid(dec_valid), .dec_kind(dec_kind_w), .dec_imm(dec_imm_w),
    .dec_addr(dec_addr)
  );

  pipe3_execute #(.AW(AW), .LOAD_EXTRA(LOAD_EXTRA), .PW(PW)) u_execute (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid), .dec_kind(dec_kind_w), .dec_imm(dec_imm_w),
    .dec_addr(dec_addr), .pc(pc),
    .ex_valid(ex_valid), .ex_kind(ex_kind_w), .ex_addr(ex_addr),
    .ex_phase(ex_phase), .stall(stall), .redirect(redirect),
    .target(target), .link_we(link_we), .link_data(link_data)
  );

  assign imem_addr = pc;
  assign ex_kind   = ex_kind_w;

  AST_PC_AHEAD: assert property (@(posedge clk) disable iff (rst)
    ex_valid |-> (pc == ex_addr + AHEAD2)); // R3

  AST_DEC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && ex_valid) |-> (dec_addr == ex_addr + AHEAD1)); // R4

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!ex_valid && !dec_valid && !stall)); // R7

  AST_LOAD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc)); // R5

endmodule

// File: tb/pipe3_core_test.sv
`timescale 1ns/1ps
module pipe3_core_test;
  localparam int AW = 32;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          dec_valid, ex_valid, link_we, redirect;
  logic [AW-1:0] dec_addr, ex_addr, link_data;
  logic [1:0]    ex_kind;
  logic [PW-1:0] ex_phase;

  logic [31:0] mem [0:63];
  assign imem_rdata = mem[imem_addr[7:2]];

  always #10 clk = ~clk;

  pipe3_core #(.AW(AW), .LOAD_EXTRA(2), .PW(PW)) uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .ex_valid(ex_valid),
    .ex_addr(ex_addr), .ex_kind(ex_kind), .ex_phase(ex_phase),
    .link_we(link_we), .link_data(link_data), .redirect(redirect)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input int a);
    logic [31:0] w;
    w = mem[a[7:2]];
    if (w[31:24] == 8'h40) return 1;
    if (w[31:24] == 8'h80) return 2;
    return 0;
  endfunction

  // behavioural reference state
  int r_pc, r_da, r_ea, r_ph;
  bit r_dv, r_ev;

  task automatic ref_reset();
    r_pc = 0; r_dv = 0; r_ev = 0; r_da = 0; r_ea = 0; r_ph = 0;
  endtask

  task automatic ref_step();
    int k;
    logic [31:0] w;
    k = r_ev ? kind_of(r_ea) : 0;
    if (k == 2) begin
      w = mem[r_ea[7:2]];
      r_pc = r_ea + 8 + 4 * int'($signed(w[23:0]));
      r_dv = 0; r_ev = 0; r_ph = 0;
    end else if (k == 1 && r_ph < 2) begin
      r_ph++;
    end else begin
      r_ev = r_dv; r_ea = r_da;
      r_dv = 1; r_da = r_pc;
      r_pc += 4; r_ph = 0;
    end
  endtask

  task automatic compare_all();
    int k;
    k = r_ev ? kind_of(r_ea) : 0;
    chk("R1", "imem_addr", imem_addr, r_pc);
    chk("R2", "ex_valid", ex_valid, r_ev);
    chk("R4", "dec_valid", dec_valid, r_dv);
    if (r_dv) chk("R4", "dec_addr", dec_addr, r_da);
    if (r_ev) begin
      chk("R3", "ex_addr", ex_addr, r_ea);
      chk("R8", "ex_kind", ex_kind, k);
      chk("R5", "ex_phase", ex_phase, r_ph);
    end
    chk("R6", "link_we", link_we, (k == 2));
    chk("R7", "redirect", redirect, (k == 2));
    if (k == 2) chk("R6", "link_data", link_data, r_ea + 4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = 32'h0000_0000;   // normal
    mem[1]  = 32'hC300_0001;   // normal, unusual top byte
    mem[2]  = 32'h4000_0123;   // load
    mem[3]  = 32'h1234_5678;   // normal
    mem[4]  = 32'h8000_0004;   // branch +4 words -> 40
    mem[5]  = 32'h4000_0000;   // load in branch shadow (flushed)
    mem[6]  = 32'h8000_0000;   // branch in shadow (flushed)
    mem[10] = 32'h0100_0000;   // normal at 40
    mem[11] = 32'h80FF_FFF4;   // branch -12 words -> 4

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_reset();
    for (int cyc = 1; cyc <= 40; cyc++) begin
      compare_all();
      // fixed reference trace points
      if (cyc == 1) begin
        chk("R2", "cycle1 dec_valid", dec_valid, 0);
        chk("R2", "cycle1 ex_valid", ex_valid, 0);
      end
      if (cyc == 2) begin
        chk("R2", "cycle2 dec_addr", dec_addr, 0);
        chk("R2", "cycle2 ex_valid", ex_valid, 0);
      end
      if (cyc == 3) begin
        chk("R2", "cycle3 ex_addr", ex_addr, 0);
        chk("R3", "cycle3 pc", imem_addr, 8);
      end
      if (cyc == 6) chk("R5", "load memory phase", ex_phase, 1);
      if (cyc == 7) begin
        chk("R5", "load writeback phase", ex_phase, 2);
        chk("R5", "pc frozen", imem_addr, 16);
      end
      if (cyc == 9) chk("R6", "forward link", link_data, 20);
      if (cyc == 10) begin
        chk("R7", "target fetched", imem_addr, 40);
        chk("R7", "bubble", ex_valid, 0);
      end
      if (cyc == 12) chk("R7", "target in execute", ex_addr, 40);
      if (cyc == 13) chk("R6", "backward link", link_data, 48);
      if (cyc == 14) chk("R7", "backward target", imem_addr, 4);
      @(posedge clk);
      ref_step();
      @(negedge clk);
    end

    // R9: synchronous reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "pc after reset", imem_addr, 0);
    chk("R9", "dec_valid after reset", dec_valid, 0);
    chk("R9", "ex_valid after reset", ex_valid, 0);
    chk("R9", "link_we after reset", link_we, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule